// File: doc/BRIEF.md
# Pipeline Interlock and Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline: fetch, decode/register read, execute, data access and write back. Each cycle the decoder presents the instruction sitting in decode: its two source register numbers, its destination register number, and flags saying whether it is valid, whether it is a load and whether it is a branch. The block carries these fields down a small shadow pipeline for execute, data access and write back. From that shadow copy it derives the operand bypass selects for the instruction in execute, the global stall, the fetch steering and the register-file write control.

A result computed one instruction earlier sits at the output of execute. That instruction is now in the data-access stage, and its result is bypassed over the near path. A result two instructions earlier sits at the output of data access. That instruction is now in write back, and its result comes over the far path. A load's data exists only at the end of data access. An execute-stage consumer of the load directly ahead of it therefore freezes the whole pipeline for exactly one cycle. During that cycle the load data settles, and afterwards it is delivered over the near path. Branches resolve in execute and redirect fetch. The instruction already in decode is the delay slot and always completes.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is held, stall is 0, both operand selects are 0 (register file), fetch select is 0 (sequential) and rf_we is 0.
- R2: A source of the valid instruction in execute that equals the nonzero destination of the valid instruction one stage ahead (data access) gets select 1 (near bypass).
- R3: A source that matches only the nonzero destination of the valid instruction two stages ahead (write back) gets select 2 (far bypass).
- R4: When both the near and the far instruction write the same source register, select 1 (the younger result) wins.
- R5: Register 0 never selects a bypass and never causes a stall. An instruction with destination 0 (such as a store) never writes the register file.
- R6: When the instruction in execute reads the nonzero destination of a load in the data-access stage, stall is 1 for exactly one cycle. In the following cycle that operand gets select 1.
- R7: While stall is 1, every tracked stage holds its contents and rf_we is 0. The instruction in decode must be held by the decoder and is taken once stall falls.
- R8: A load followed by its consumer two instructions later causes no stall, and the consumer gets select 2.
- R9: Fetch select is 2 (hold) while stalled. Otherwise it is 1 (branch target) when a valid branch is in execute and ex_br_taken is 1, and 0 (sequential) in all other cases.
- R10: The instruction in decode when a taken branch leaves execute is never squashed: it reaches write back and writes its destination like any other instruction.
- R11: rf_we is 1, with rf_waddr equal to that destination, exactly when a valid instruction with nonzero destination is in write back and stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_src_a | input | REG_W | First source register of the decode instruction (0 = unused) |
| id_src_b | input | REG_W | Second source register of the decode instruction (0 = unused) |
| id_dest | input | REG_W | Destination register (0 = no register result) |
| id_load | input | 1 | Decode instruction is a load |
| id_branch | input | 1 | Decode instruction is a branch |
| ex_br_taken | input | 1 | Branch condition for the execute instruction is true |
| stall | output | 1 | Global freeze of all stages |
| fwd_sel_a | output | 2 | Operand A source for execute: 0 register file, 1 near, 2 far |
| fwd_sel_b | output | 2 | Operand B source for execute, same encoding |
| fetch_sel | output | 2 | Next fetch address: 0 sequential, 1 branch target, 2 hold |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_W | Register file write address |

## Verification
Directed sequences come first. They cover back-to-back dependent ALU operations, which separate near bypass from register read, and a producer two instructions back, which separates far bypass from near. A load with an immediate consumer must give exactly one stall cycle and then the near path. A load with a consumer two instructions later must give no stall and the far path. Two writers of one register check near-over-far priority. Register 0 as source and destination checks R5. A taken branch whose delay slot must still write back checks R9 and R10. A long constrained-random stream over four registers then mixes loads, stores, branches and bubbles, so that stalls meet branches and double matches meet register 0. Every cycle is compared against a bench reference model of the stage occupancy.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam logic [1:0] SEL_RF   = 2'd0;
  localparam logic [1:0] SEL_NEAR = 2'd1;
  localparam logic [1:0] SEL_FAR  = 2'd2;

  localparam logic [1:0] FS_SEQ   = 2'd0;
  localparam logic [1:0] FS_TGT   = 2'd1;
  localparam logic [1:0] FS_HOLD  = 2'd2;

  localparam int unsigned N_OPND  = 2;
  localparam int unsigned N_TRACK = 3; // execute, data access, write back
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/stage_track.sv
module stage_track #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NSTG  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        in_valid,
  input  logic [REG_W-1:0]            in_dest,
  input  logic                        in_load,
  input  logic                        in_branch,
  input  logic [1:0][REG_W-1:0]       in_src,
  output logic [NSTG-1:0]             st_valid,
  output logic [NSTG-1:0][REG_W-1:0]  st_dest,
  output logic [NSTG-1:0]             st_load,
  output logic [NSTG-1:0]             st_branch,
  output logic [1:0][REG_W-1:0]       ex_src
);
  logic [NSTG-1:0]            valid_d, valid_q;
  logic [NSTG-1:0][REG_W-1:0] dest_d, dest_q;
  logic [NSTG-1:0]            load_d, load_q;
  logic [NSTG-1:0]            br_d, br_q;
  logic [1:0][REG_W-1:0]      src_d, src_q;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_comb begin
        valid_d[s] = valid_q[s];
        dest_d[s]  = dest_q[s];
        load_d[s]  = load_q[s];
        br_d[s]    = br_q[s];
        if (adv) begin
          valid_d[s] = in_valid;
          dest_d[s]  = in_dest;
          load_d[s]  = in_load;
          br_d[s]    = in_branch;
        end
      end
    end else begin : g_body
      always_comb begin
        valid_d[s] = valid_q[s];
        dest_d[s]  = dest_q[s];
        load_d[s]  = load_q[s];
        br_d[s]    = br_q[s];
        if (adv) begin
          valid_d[s] = valid_q[s-1];
          dest_d[s]  = dest_q[s-1];
          load_d[s]  = load_q[s-1];
          br_d[s]    = br_q[s-1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
        dest_q[s]  <= '0;
        load_q[s]  <= 1'b0;
        br_q[s]    <= 1'b0;
      end else begin
        valid_q[s] <= valid_d[s];
        dest_q[s]  <= dest_d[s];
        load_q[s]  <= load_d[s];
        br_q[s]    <= br_d[s];
      end
    end
  end

  always_comb begin
    src_d = src_q;
    if (adv) src_d = in_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign st_valid  = valid_q;
  assign st_dest   = dest_q;
  assign st_load   = load_q;
  assign st_branch = br_q;
  assign ex_src    = src_q;

  // R7: a frozen cycle leaves every tracked stage untouched
  assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(valid_q) && $stable(dest_q) && $stable(load_q) && $stable(src_q)));

  // R7: an advancing cycle moves the execute entry one stage down
  assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (valid_q[1] == $past(valid_q[0]) && dest_q[1] == $past(dest_q[0])));
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] src,
  input  logic             near_valid,
  input  logic [REG_W-1:0] near_dest,
  input  logic             far_valid,
  input  logic [REG_W-1:0] far_dest,
  output logic [1:0]       sel
);
  import hz_pkg::*;

  logic src_live, near_hit, far_hit;

  always_comb begin
    src_live = ex_valid && (src != '0);
    near_hit = src_live && near_valid && (near_dest == src);
    far_hit  = src_live && far_valid && (far_dest == src);
    if (near_hit)     sel = SEL_NEAR;
    else if (far_hit) sel = SEL_FAR;
    else              sel = SEL_RF;
  end

  // R5: register 0 is never taken from a bypass path
  assert_r0_no_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SEL_RF));

  // R4: the far path is only used when the near stage does not write the source
  assert_near_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_FAR) |-> !(near_valid && near_dest == src));
endmodule

// File: rtl/load_interlock.sv
module load_interlock #(
  parameter int unsigned REG_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ex_valid,
  input  logic [1:0][REG_W-1:0] ex_src,
  input  logic                  dc_valid,
  input  logic                  dc_load,
  input  logic [REG_W-1:0]      dc_dest,
  output logic                  stall
);
  logic ld_ready_d, ld_ready_q;
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (ex_src[i] == dc_dest) hit = 1'b1;
    end
    hit        = hit && ex_valid && dc_valid && dc_load && (dc_dest != '0);
    stall      = hit && !ld_ready_q;
    ld_ready_d = stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_ready_q <= 1'b0;
    else        ld_ready_q <= ld_ready_d;
  end

  // R6: a load-use freeze never lasts more than one cycle
  assert_stall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R5: a load into register 0 never freezes the pipeline
  assert_r0_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_dest == '0) |-> !stall);
endmodule

// File: rtl/fetch_steer.sv
module fetch_steer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall,
  input  logic       ex_valid,
  input  logic       ex_branch,
  input  logic       ex_br_taken,
  output logic [1:0] fetch_sel
);
  import hz_pkg::*;

  always_comb begin
    if (stall)                                   fetch_sel = FS_HOLD;
    else if (ex_valid && ex_branch && ex_br_taken) fetch_sel = FS_TGT;
    else                                         fetch_sel = FS_SEQ;
  end

  // R9: a redirect needs a valid branch in execute
  assert_tgt_needs_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_sel == FS_TGT) |-> (ex_valid && ex_branch));

  // R9: fetch never advances while frozen
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (fetch_sel == FS_HOLD));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] id_dest,
  input  logic             id_load,
  input  logic             id_branch,
  input  logic             ex_br_taken,
  output logic             stall,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic [1:0]       fetch_sel,
  output logic             rf_we,
  output logic [REG_W-1:0] rf_waddr
);
  import hz_pkg::*;

  localparam int unsigned NSTG = N_TRACK;
  localparam int unsigned S_EX = 0;
  localparam int unsigned S_DC = 1;
  localparam int unsigned S_WB = 2;

  logic                       rst_n_s;
  logic [NSTG-1:0]            st_valid;
  logic [NSTG-1:0][REG_W-1:0] st_dest;
  logic [NSTG-1:0]            st_load;
  logic [NSTG-1:0]            st_branch;
  logic [1:0][REG_W-1:0]      in_src, ex_src;
  logic [N_OPND-1:0][1:0]     sel;
  logic                       stall_i;

  rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign in_src = {id_src_b, id_src_a};

  stage_track #(.REG_W(REG_W), .NSTG(NSTG)) u_track (
    .clk(clk), .rst_n(rst_n_s), .adv(!stall_i),
    .in_valid(id_valid), .in_dest(id_dest), .in_load(id_load),
    .in_branch(id_branch), .in_src(in_src),
    .st_valid(st_valid), .st_dest(st_dest), .st_load(st_load),
    .st_branch(st_branch), .ex_src(ex_src)
  );

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    fwd_pick #(.REG_W(REG_W)) u_pick (
      .clk(clk), .rst_n(rst_n_s),
      .ex_valid(st_valid[S_EX]), .src(ex_src[k]),
      .near_valid(st_valid[S_DC]), .near_dest(st_dest[S_DC]),
      .far_valid(st_valid[S_WB]), .far_dest(st_dest[S_WB]),
      .sel(sel[k])
    );
  end

  load_interlock #(.REG_W(REG_W)) u_ilock (
    .clk(clk), .rst_n(rst_n_s),
    .ex_valid(st_valid[S_EX]), .ex_src(ex_src),
    .dc_valid(st_valid[S_DC]), .dc_load(st_load[S_DC]),
    .dc_dest(st_dest[S_DC]), .stall(stall_i)
  );

  fetch_steer u_fetch (
    .clk(clk), .rst_n(rst_n_s), .stall(stall_i),
    .ex_valid(st_valid[S_EX]), .ex_branch(st_branch[S_EX]),
    .ex_br_taken(ex_br_taken), .fetch_sel(fetch_sel)
  );

  always_comb begin
    stall     = stall_i;
    fwd_sel_a = sel[0];
    fwd_sel_b = sel[1];
    rf_we     = st_valid[S_WB] && (st_dest[S_WB] != '0) && !stall_i;
    rf_waddr  = st_dest[S_WB];
  end

  // R7: no register file write during a freeze
  assert_no_write_in_stall_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    stall |-> !rf_we);

  // R5: register 0 is never written
  assert_r0_never_written_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    rf_we |-> (rf_waddr != '0));
endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  localparam int unsigned REG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             id_valid = 1'b0;
  logic [REG_W-1:0] id_src_a = '0, id_src_b = '0, id_dest = '0;
  logic             id_load = 1'b0, id_branch = 1'b0, ex_br_taken = 1'b0;
  logic             stall, rf_we;
  logic [1:0]       fwd_sel_a, fwd_sel_b, fetch_sel;
  logic [REG_W-1:0] rf_waddr;

  int tests = 0, fails = 0;
  int stall_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(REG_W)) u_pipe_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_src_a(id_src_a),
    .id_src_b(id_src_b), .id_dest(id_dest), .id_load(id_load),
    .id_branch(id_branch), .ex_br_taken(ex_br_taken), .stall(stall),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .fetch_sel(fetch_sel),
    .rf_we(rf_we), .rf_waddr(rf_waddr)
  );

  // bench reference: occupancy of execute, data access, write back
  bit               m_v[3];
  bit               m_ld[3];
  bit               m_br[3];
  logic [REG_W-1:0] m_d[3];
  logic [REG_W-1:0] m_a, m_b;
  bit               m_ready;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_sel(input logic [REG_W-1:0] s);
    if (!m_v[0] || s == 0) return 0;
    if (m_v[1] && m_d[1] == s) return 1;
    if (m_v[2] && m_d[2] == s) return 2;
    return 0;
  endfunction

  function automatic bit exp_stall();
    return m_v[0] && m_v[1] && m_ld[1] && m_d[1] != 0 &&
           (m_a == m_d[1] || m_b == m_d[1]) && !m_ready;
  endfunction

  function automatic string sel_tag(input logic [REG_W-1:0] s, input int e);
    if (e == 1 && m_v[2] && m_d[2] == s) return "R4";
    if (e == 1 && m_ld[1]) return "R6";
    if (e == 1) return "R2";
    if (e == 2) return "R3/R8";
    return "R5";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_v[i] = 0; m_ld[i] = 0; m_br[i] = 0; m_d[i] = '0;
    end
    m_a = '0; m_b = '0; m_ready = 0;
  endtask

  // present one instruction in decode until the controller accepts it
  task automatic issue(input bit v, input int a, input int b, input int d,
                       input bit ld, input bit br, input bit tk);
    bit taken_in = 0;
    while (!taken_in) begin
      bit es;
      int ea, eb, ef;
      @(negedge clk);
      id_valid = v; id_src_a = a[REG_W-1:0]; id_src_b = b[REG_W-1:0];
      id_dest = d[REG_W-1:0]; id_load = ld; id_branch = br; ex_br_taken = tk;
      #1;
      es = exp_stall();
      ea = exp_sel(m_a);
      eb = exp_sel(m_b);
      ef = es ? 2 : ((m_v[0] && m_br[0] && tk) ? 1 : 0);
      chk("R6 stall", int'(stall), int'(es));
      chk({sel_tag(m_a, ea), " sel_a"}, int'(fwd_sel_a), ea);
      chk({sel_tag(m_b, eb), " sel_b"}, int'(fwd_sel_b), eb);
      chk("R9 fetch_sel", int'(fetch_sel), ef);
      // R10 R11: write back from the model, delay slots included
      chk("R11 rf_we", int'(rf_we), int'(m_v[2] && m_d[2] != 0 && !es));
      if (rf_we) chk("R11 rf_waddr", int'(rf_waddr), int'(m_d[2]));
      if (stall) stall_cnt++;
      @(posedge clk);
      if (es) begin
        m_ready = 1;   // R7: everything holds
      end else begin
        for (int i = 2; i > 0; i--) begin
          m_v[i] = m_v[i-1]; m_ld[i] = m_ld[i-1]; m_br[i] = m_br[i-1]; m_d[i] = m_d[i-1];
        end
        m_v[0] = v; m_ld[0] = ld; m_br[0] = br; m_d[0] = d[REG_W-1:0];
        m_a = a[REG_W-1:0]; m_b = b[REG_W-1:0];
        m_ready = 0;
        taken_in = 1;
      end
    end
  endtask

  task automatic bubbles(input int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    int seed = 32'h5eed_c0de;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset stall", int'(stall), 0);
    chk("R1 reset sel_a", int'(fwd_sel_a), 0);
    chk("R1 reset sel_b", int'(fwd_sel_b), 0);
    chk("R1 reset fetch_sel", int'(fetch_sel), 0);
    chk("R1 reset rf_we", int'(rf_we), 0);
    rst_n = 1'b1;
    bubbles(4);

    // R2: back-to-back dependent ALU ops
    issue(1, 2, 3, 1, 0, 0, 0);
    issue(1, 1, 1, 4, 0, 0, 0);
    issue(1, 4, 1, 5, 0, 0, 0);   // R2 on a, R3 on b
    bubbles(4);

    // R6: load with immediate consumer -> exactly one stall cycle
    stall_cnt = 0;
    issue(1, 0, 0, 6, 1, 0, 0);
    issue(1, 6, 2, 7, 0, 0, 0);
    bubbles(4);
    chk("R6 stall cycles for load-use", stall_cnt, 1);

    // R8: load, independent op, consumer -> no stall, far path
    stall_cnt = 0;
    issue(1, 0, 0, 8, 1, 0, 0);
    issue(1, 2, 3, 9, 0, 0, 0);
    issue(1, 3, 8, 10, 0, 0, 0);
    bubbles(4);
    chk("R8 stall cycles for distant consumer", stall_cnt, 0);

    // R4: two writers of the same register
    issue(1, 0, 0, 11, 0, 0, 0);
    issue(1, 0, 0, 11, 0, 0, 0);
    issue(1, 11, 11, 12, 0, 0, 0);
    bubbles(4);

    // R5: register 0 as destination and as source, also a load into r0
    stall_cnt = 0;
    issue(1, 1, 2, 0, 1, 0, 0);
    issue(1, 0, 0, 13, 0, 0, 0);
    issue(1, 0, 0, 0, 0, 0, 0);
    bubbles(4);
    chk("R5 no stall on r0", stall_cnt, 0);

    // R9 R10: taken branch, delay slot writes back
    issue(1, 1, 2, 0, 0, 1, 0);
    issue(1, 3, 0, 14, 0, 0, 1);  // delay slot, branch taken in execute
    issue(1, 14, 0, 15, 0, 0, 0); // target instruction uses delay slot result
    bubbles(4);

    // branch behind a load it depends on: hold, then redirect
    issue(1, 0, 0, 16, 1, 0, 0);
    issue(1, 16, 0, 0, 0, 1, 1);
    issue(1, 0, 0, 17, 0, 0, 1);
    bubbles(4);

    // constrained random stream
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(99);
      bit v  = (r < 88);
      bit ld = ($urandom_range(99) < 30);
      bit br = !ld && ($urandom_range(99) < 15);
      int d  = (br || $urandom_range(9) == 0) ? 0 : $urandom_range(3);
      issue(v, $urandom_range(3), $urandom_range(3), d, ld, br, $urandom_range(1) == 1);
    end
    bubbles(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule